// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a 16-bit-per-pixel frame held in memory. It does two things. It fills a rectangle with one colour, and it copies a rectangle from one place to another. Software writes 32-bit command words. The top eight bits of each word are an opcode and the low 24 bits are its operand. Most words set one parameter: destination start, source start, width, height, fill colour or row pitch. A final go word starts the operation.

Pixels are stored in RGB565 layout, and the engine never takes a pixel apart. It moves one pixel per memory access over a simple 16-bit port with a request/ready handshake, and it keeps at most one request open. A copy can walk each axis of the source and of the destination in reverse. This makes overlapping source and destination areas come out correctly, and it also allows mirrored copies. While an operation runs, the engine holds busy high and refuses every new command word. At the end it pulses done, and it also pulses irq if the go word asked for one.

Top module: `rect_blit_engine`

## Requirements
- R1: A command word is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is high exactly when the engine is not busy, so parameter loads and go words are held off during an operation. The parameter registers do not change while busy.
- R2: Opcode 0x0C loads the destination start and opcode 0x0D loads the source start. Each is a 24-bit byte address taken from operand bits 23:0, with bit 0 forced to zero.
- R3: Opcode 0x0E loads the width and opcode 0x0F loads the height. Each comes from operand bits 9:0, holds the count minus one, and ignores the upper operand bits.
- R4: Opcode 0x0B loads the 16-bit fill colour from operand bits 15:0.
- R5: Opcode 0x30 loads the row pitch in pixels from operand bits 10:0. After reset the pitch is DISP_W, which defaults to 320.
- R6: The pixel at row r and column c of a rectangle that starts at byte address B lives at B + (r*pitch + c)*2, taken modulo 2^24.
- R7: Opcode 0x23 starts a fill. It issues exactly width*height writes of the fill colour. The writes go row by row from the top, and left to right within each row.
- R8: Opcode 0x21 starts a copy. For each pixel it makes one read from the source and then one write of that value to the destination, so reads and writes strictly alternate.
- R9: In a copy go word, the operand bits reverse the traversal of one axis. Bit 4 reverses the destination rows, bit 5 the destination columns, bit 6 the source rows and bit 7 the source columns. On step k, both the read and the write take the k-th pixel in their own order. A fill ignores all four bits.
- R10: The engine has at most one request open at a time. While mem_req is high and mem_ready is low, the next cycle keeps mem_req high with mem_addr, mem_we and mem_wdata unchanged.
- R11: busy goes high in the cycle after a go word is taken. It stays high until the handshake of the last write. In the following cycle busy is low and done is high for exactly one cycle.
- R12: If bit 1 of the go word is set, irq pulses in the same cycle as done. If it is clear, irq stays low.
- R13: A word with any other opcode is taken and has no effect. It changes no parameter and causes no memory access.
- R14: After reset, busy, done, irq and mem_req are low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 32 | Opcode in 31:24, operand in 23:0 |
| cmd_ready | output | 1 | Engine can take a command word |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the pixel (always even) |
| mem_wdata | output | 16 | Pixel to write |
| mem_ready | input | 1 | Access completes on this edge |
| mem_rdata | input | 16 | Read pixel, valid while mem_ready is high on a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last write |
| irq | output | 1 | Completion pulse when the go word asked for it |

## Verification
Fills are run in several forms: a 2x2 fill with the reset pitch, a 1x1 fill, and a 5x3 fill at an odd start address with random stalls. Together these separate the default-pitch, minus-one and even-address rules. Copies are tried in three ways. A forward copy with no overlap checks the read/write alternation and the masking of the width field. A copy to a region one row down and one column right, with all four reverse bits set, passes only if the walk starts at the far corner. A copy with only the destination columns reversed checks the exact bit positions of the flags. Further runs check that a colour load is held off until the running fill ends, and that words with unknown or out-of-scope opcodes leave both memory and parameters untouched.

// File: rtl/blit_pkg.sv
package blit_pkg;

    // Fixed command word format
    localparam int CMD_W   = 32;
    localparam int OP_W    = 8;
    localparam int OPR_W   = CMD_W - OP_W;
    localparam int ADDR_W  = 24;
    localparam int PIX_W   = 16;
    localparam int DIM_W   = 10;
    localparam int PITCH_W = 11;

    // Opcodes
    localparam logic [OP_W-1:0] OPC_COLOR   = 8'h0B;
    localparam logic [OP_W-1:0] OPC_DST     = 8'h0C;
    localparam logic [OP_W-1:0] OPC_SRC     = 8'h0D;
    localparam logic [OP_W-1:0] OPC_WIDTH   = 8'h0E;
    localparam logic [OP_W-1:0] OPC_HEIGHT  = 8'h0F;
    localparam logic [OP_W-1:0] OPC_COPY_GO = 8'h21;
    localparam logic [OP_W-1:0] OPC_FILL_GO = 8'h23;
    localparam logic [OP_W-1:0] OPC_PITCH   = 8'h30;

    // Go-word operand bit positions
    localparam int GO_IRQ_BIT  = 1;
    localparam int GO_DVRV_BIT = 4;
    localparam int GO_DHRV_BIT = 5;
    localparam int GO_SVRV_BIT = 6;
    localparam int GO_SHRV_BIT = 7;

    typedef struct packed {
        logic [ADDR_W-1:0]  dst;
        logic [ADDR_W-1:0]  src;
        logic [DIM_W-1:0]   wm1;
        logic [DIM_W-1:0]   hm1;
        logic [PIX_W-1:0]   color;
        logic [PITCH_W-1:0] pitch;
    } blit_params_t;

    typedef struct packed {
        logic is_copy;
        logic want_irq;
        logic dst_vrev;
        logic dst_hrev;
        logic src_vrev;
        logic src_hrev;
    } go_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL_WR,
        ST_COPY_RD,
        ST_COPY_WR
    } eng_state_e;

    // Position along one axis, walked forward or backward
    function automatic logic [DIM_W-1:0] axis_pos(
        input logic             rev,
        input logic [DIM_W-1:0] cnt,
        input logic [DIM_W-1:0] last
    );
        return rev ? (last - cnt) : cnt;
    endfunction

    // Byte address of a pixel inside a rectangle
    function automatic logic [ADDR_W-1:0] pixel_addr(
        input logic [ADDR_W-1:0]  base,
        input logic [DIM_W-1:0]   row,
        input logic [DIM_W-1:0]   col,
        input logic [PITCH_W-1:0] pitch
    );
        logic [ADDR_W-1:0] off;
        off = ADDR_W'(row) * ADDR_W'(pitch) + ADDR_W'(col);
        return base + (off << 1);
    endfunction

endpackage

// File: rtl/blit_param_regs.sv
module blit_param_regs
    import blit_pkg::*;
#(
    parameter int DISP_W = 320
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_fire,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             busy,
    output blit_params_t     prm,
    output logic             go_fire,
    output go_flags_t        go_flags
);

    localparam logic [PITCH_W-1:0] PITCH_RST = PITCH_W'(DISP_W);

    logic [OP_W-1:0]  opc;
    logic [OPR_W-1:0] opr;
    blit_params_t     prm_q;
    logic             is_copy_go;
    logic             is_fill_go;

    assign opc = cmd_data[CMD_W-1:OPR_W];
    assign opr = cmd_data[OPR_W-1:0];

    assign is_copy_go = (opc == OPC_COPY_GO);
    assign is_fill_go = (opc == OPC_FILL_GO);

    always_ff @(posedge clk) begin
        if (rst) begin
            prm_q.dst   <= '0;
            prm_q.src   <= '0;
            prm_q.wm1   <= '0;
            prm_q.hm1   <= '0;
            prm_q.color <= '0;
            prm_q.pitch <= PITCH_RST;
        end else if (cmd_fire) begin
            case (opc)
                OPC_DST:    prm_q.dst   <= {opr[ADDR_W-1:1], 1'b0};
                OPC_SRC:    prm_q.src   <= {opr[ADDR_W-1:1], 1'b0};
                OPC_WIDTH:  prm_q.wm1   <= opr[DIM_W-1:0];
                OPC_HEIGHT: prm_q.hm1   <= opr[DIM_W-1:0];
                OPC_COLOR:  prm_q.color <= opr[PIX_W-1:0];
                OPC_PITCH:  prm_q.pitch <= opr[PITCH_W-1:0];
                default:    ;
            endcase
        end
    end

    assign prm = prm_q;

    always_comb begin
        go_fire           = cmd_fire && (is_copy_go || is_fill_go);
        go_flags.is_copy  = is_copy_go;
        go_flags.want_irq = opr[GO_IRQ_BIT];
        go_flags.dst_vrev = is_copy_go && opr[GO_DVRV_BIT];
        go_flags.dst_hrev = is_copy_go && opr[GO_DHRV_BIT];
        go_flags.src_vrev = is_copy_go && opr[GO_SVRV_BIT];
        go_flags.src_hrev = is_copy_go && opr[GO_SHRV_BIT];
    end

    // R1
    param_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(prm_q));

endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             start,
    input  logic             step,
    input  logic [DIM_W-1:0] wm1,
    input  logic [DIM_W-1:0] hm1,
    output logic [DIM_W-1:0] cx,
    output logic [DIM_W-1:0] cy,
    output logic             last
);

    logic row_end;

    assign row_end = (cx == wm1);
    assign last    = row_end && (cy == hm1);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cx <= '0;
            cy <= '0;
        end else if (step) begin
            if (last) begin
                cx <= '0;
                cy <= '0;
            end else if (row_end) begin
                cx <= '0;
                cy <= cy + 1'b1;
            end else begin
                cx <= cx + 1'b1;
            end
        end
    end

    // R7
    walker_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cx <= wm1 && cy <= hm1));

endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_fire,
    input  go_flags_t         go_flags,
    input  blit_params_t      prm,
    input  logic [DIM_W-1:0]  cx,
    input  logic [DIM_W-1:0]  cy,
    input  logic              last,
    output logic              start,
    output logic              step,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic              mem_ready,
    input  logic [PIX_W-1:0]  mem_rdata
);

    eng_state_e        state_q, state_nx;
    go_flags_t         flags_q;
    logic [PIX_W-1:0]  hold_q;
    logic              hs;
    logic [DIM_W-1:0]  d_row, d_col, s_row, s_col;
    logic [ADDR_W-1:0] dst_a, src_a;

    always_comb begin
        d_row = axis_pos(flags_q.dst_vrev, cy, prm.hm1);
        d_col = axis_pos(flags_q.dst_hrev, cx, prm.wm1);
        s_row = axis_pos(flags_q.src_vrev, cy, prm.hm1);
        s_col = axis_pos(flags_q.src_hrev, cx, prm.wm1);
    end

    assign dst_a = pixel_addr(prm.dst, d_row, d_col, prm.pitch);
    assign src_a = pixel_addr(prm.src, s_row, s_col, prm.pitch);

    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (state_q != ST_COPY_RD);
    assign mem_addr  = (state_q == ST_COPY_RD) ? src_a : dst_a;
    assign mem_wdata = (state_q == ST_COPY_WR) ? hold_q : prm.color;

    assign hs    = mem_req && mem_ready;
    assign step  = hs && mem_we;
    assign start = go_fire && !busy;

    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_IDLE:    if (start) state_nx = go_flags.is_copy ? ST_COPY_RD : ST_FILL_WR;
            ST_FILL_WR: if (hs && last) state_nx = ST_IDLE;
            ST_COPY_RD: if (hs) state_nx = ST_COPY_WR;
            ST_COPY_WR: if (hs) state_nx = last ? ST_IDLE : ST_COPY_RD;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            hold_q  <= '0;
            done    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (start) flags_q <= go_flags;
            if (hs && state_q == ST_COPY_RD) hold_q <= mem_rdata;
            done <= step && last;
            irq  <= step && last && flags_q.want_irq;
        end
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R12
    irq_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import blit_pkg::*;
#(
    parameter int DISP_W = 320
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_data,
    output logic        cmd_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [23:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [15:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        irq
);

    blit_params_t     prm;
    go_flags_t        go_flags;
    logic             go_fire;
    logic             cmd_fire;
    logic             start;
    logic             step;
    logic [DIM_W-1:0] cx, cy;
    logic             last;

    assign cmd_ready = !busy;
    assign cmd_fire  = cmd_valid && cmd_ready;

    blit_param_regs #(.DISP_W(DISP_W)) u_params (
        .clk      (clk),
        .rst      (rst),
        .cmd_fire (cmd_fire),
        .cmd_data (cmd_data),
        .busy     (busy),
        .prm      (prm),
        .go_fire  (go_fire),
        .go_flags (go_flags)
    );

    blit_walker u_walker (
        .clk    (clk),
        .rst    (rst),
        .active (busy),
        .start  (start),
        .step   (step),
        .wm1    (prm.wm1),
        .hm1    (prm.hm1),
        .cx     (cx),
        .cy     (cy),
        .last   (last)
    );

    blit_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go_fire   (go_fire),
        .go_flags  (go_flags),
        .prm       (prm),
        .cx        (cx),
        .cy        (cy),
        .last      (last),
        .start     (start),
        .step      (step),
        .busy      (busy),
        .done      (done),
        .irq       (irq),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata)
    );

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && cmd_ready));

endmodule

// File: tb/rect_blit_engine_tb_top.sv
module rect_blit_engine_tb_top;

    localparam int MEM_WORDS = 4096;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic        cmd_ready;
    logic        mem_req, mem_we, mem_ready;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, done, irq;

    always #2 clk = ~clk;

    rect_blit_engine dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .irq(irq)
    );

    logic [15:0] mem_arr [MEM_WORDS];
    logic [15:0] exp_arr [MEM_WORDS];
    assign mem_rdata = mem_arr[mem_addr[12:1]];

    int total = 0;
    int bad = 0;

    // bench copy of parameters
    int cur_dst, cur_src, cur_w, cur_h, cur_pitch;
    logic [15:0] cur_color;

    // monitor state
    int ev_q[$];
    int hold_err = 0, done_err = 0, irq_err = 0, done_cnt = 0, irq_cnt = 0;
    bit prev_wait = 0, prev_wr_hs = 0, prev_we = 0;
    logic [23:0] prev_addr = '0;
    logic [15:0] prev_wdata = '0;
    bit stall_on = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int widx(input int a);
        return (a >> 1) & (MEM_WORDS - 1);
    endfunction

    function automatic logic [31:0] cw(input logic [7:0] op, input logic [23:0] opr);
        return {op, opr};
    endfunction

    // ready driver, changes just after the edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = stall_on ? (lfsr[0] & lfsr[3]) : 1'b1;
    end

    // memory model and port monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_wait && !(mem_req && mem_addr == prev_addr && mem_we == prev_we
                               && mem_wdata == prev_wdata))
                hold_err++;
            if (done && (!prev_wr_hs || busy)) done_err++;
            if (irq && !done) irq_err++;
            if (done) done_cnt++;
            if (irq) irq_cnt++;
            prev_wait  = mem_req && !mem_ready;
            prev_addr  = mem_addr;
            prev_we    = mem_we;
            prev_wdata = mem_wdata;
            prev_wr_hs = mem_req && mem_ready && mem_we;
            if (mem_req && mem_ready) begin
                ev_q.push_back((int'(mem_we) << 24) | int'(mem_addr));
                if (mem_we) mem_arr[mem_addr[12:1]] = mem_wdata;
            end
        end
    end

    task automatic send(input logic [31:0] w);
        bit acc;
        @(posedge clk);
        #1;
        cmd_valid = 1'b1;
        cmd_data  = w;
        do begin
            @(negedge clk);
            acc = cmd_ready;
            @(posedge clk);
        end while (!acc);
        #1;
        cmd_valid = 1'b0;
        cmd_data  = '0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, req, int'(busy), 0);
        @(negedge clk);
    endtask

    task automatic set_dst(input int a);   send(cw(8'h0C, 24'(a))); cur_dst = a & ~1; endtask
    task automatic set_src(input int a);   send(cw(8'h0D, 24'(a))); cur_src = a & ~1; endtask
    task automatic set_w(input int w);     send(cw(8'h0E, 24'(w - 1))); cur_w = w; endtask
    task automatic set_h(input int h);     send(cw(8'h0F, 24'(h - 1))); cur_h = h; endtask
    task automatic set_color(input logic [15:0] c); send(cw(8'h0B, {8'h00, c})); cur_color = c; endtask
    task automatic set_pitch(input int p); send(cw(8'h30, 24'(p))); cur_pitch = p; endtask

    task automatic model_fill();
        for (int r = 0; r < cur_h; r++)
            for (int c = 0; c < cur_w; c++)
                exp_arr[widx(cur_dst + (r * cur_pitch + c) * 2)] = cur_color;
    endtask

    task automatic model_copy(input bit dv, input bit dh, input bit sv, input bit sh);
        for (int y = 0; y < cur_h; y++)
            for (int x = 0; x < cur_w; x++) begin
                int dr = dv ? cur_h - 1 - y : y;
                int dc = dh ? cur_w - 1 - x : x;
                int sr = sv ? cur_h - 1 - y : y;
                int sc = sh ? cur_w - 1 - x : x;
                exp_arr[widx(cur_dst + (dr * cur_pitch + dc) * 2)] =
                    exp_arr[widx(cur_src + (sr * cur_pitch + sc) * 2)];
            end
    endtask

    task automatic compare_mem(input string req);
        int mism = 0;
        for (int i = 0; i < MEM_WORDS; i++)
            if (mem_arr[i] !== exp_arr[i]) mism++;
        chk(mism == 0, req, mism, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy,     "R14 busy",     int'(busy), 0);
        chk(!done,     "R14 done",     int'(done), 0);
        chk(!irq,      "R14 irq",      int'(irq), 0);
        chk(!mem_req,  "R14 mem_req",  int'(mem_req), 0);
        chk(cmd_ready, "R14 cmd_ready", int'(cmd_ready), 1);
    endtask

    // R5 default pitch, R6 addressing, R7 fill order, R11 busy timing
    task automatic t_default_pitch();
        int d0 = done_cnt, i0 = irq_cnt;
        set_dst(24'h100); set_w(2); set_h(2); set_color(16'hF800);
        ev_q.delete();
        send(cw(8'h23, 24'h0));
        @(negedge clk);
        chk(busy, "R11 busy after go", int'(busy), 1);
        wait_idle("R11 fill ends");
        model_fill();
        compare_mem("R5 fill with reset pitch");
        chk(ev_q.size() == 4, "R7 write count", ev_q.size(), 4);
        if (ev_q.size() == 4) begin
            chk(ev_q[2] == ((1 << 24) | (24'h100 + 640)), "R6 row1 address", ev_q[2],
                (1 << 24) | (24'h100 + 640));
            chk(ev_q[1] == ((1 << 24) | 24'h102), "R7 second write", ev_q[1], (1 << 24) | 24'h102);
        end
        chk(done_cnt == d0 + 1, "R11 one done pulse", done_cnt - d0, 1);
        chk(irq_cnt == i0, "R12 no irq without bit", irq_cnt - i0, 0);
    endtask

    // R3 single pixel, R12 irq, R2 odd address
    task automatic t_fill_small();
        int i0 = irq_cnt;
        stall_on = 1;
        set_pitch(16);
        set_dst(24'h400); set_w(1); set_h(1); set_color(16'h07E0);
        ev_q.delete();
        send(cw(8'h23, 24'h000002));
        wait_idle("R11 1x1 fill ends");
        model_fill();
        compare_mem("R3 1x1 fill");
        chk(ev_q.size() == 1, "R3 one write", ev_q.size(), 1);
        chk(irq_cnt == i0 + 1, "R12 irq with bit 1", irq_cnt - i0, 1);
        set_dst(24'h401); set_w(5); set_h(3); set_color(16'h1234);
        ev_q.delete();
        send(cw(8'h23, 24'h0000F0));
        wait_idle("R11 5x3 fill ends");
        model_fill();
        compare_mem("R2 odd start forced even, R9 flags ignored by fill");
        chk(ev_q.size() == 15, "R7 5x3 write count", ev_q.size(), 15);
        if (ev_q.size() > 0)
            chk(ev_q[0] == ((1 << 24) | 24'h400), "R2 first write even", ev_q[0], (1 << 24) | 24'h400);
    endtask

    // R8 forward copy, R3 upper operand bits masked
    task automatic t_copy_fwd();
        bit alt = 1;
        set_src(24'h600); set_dst(24'h900);
        send(cw(8'h0E, {14'h3F0, 10'd3})); cur_w = 4;
        set_h(3);
        ev_q.delete();
        send(cw(8'h21, 24'h0));
        wait_idle("R11 copy ends");
        model_copy(0, 0, 0, 0);
        compare_mem("R8 forward copy");
        chk(ev_q.size() == 24, "R8 access count", ev_q.size(), 24);
        for (int i = 0; i < ev_q.size(); i++)
            if (((ev_q[i] >> 24) & 1) != (i % 2)) alt = 0;
        chk(alt, "R8 read/write alternate", int'(alt), 1);
        if (ev_q.size() > 1)
            chk(ev_q[0] == 24'h600, "R8 first read at source", ev_q[0], 24'h600);
        chk(hold_err == 0, "R10 request held while stalled", hold_err, 0);
    endtask

    // R9 overlapping copy walked from the far corner
    task automatic t_copy_overlap();
        logic [15:0] snap [16];
        int mism = 0;
        int dst = 24'hA00 + (16 + 1) * 2;
        set_src(24'hA00); set_dst(dst); set_w(4); set_h(4);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                snap[r * 4 + c] = exp_arr[widx(24'hA00 + (r * 16 + c) * 2)];
        ev_q.delete();
        send(cw(8'h21, 24'h0000F0));
        wait_idle("R11 overlap copy ends");
        model_copy(1, 1, 1, 1);
        compare_mem("R9 overlap copy order");
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (mem_arr[widx(dst + (r * 16 + c) * 2)] !== snap[r * 4 + c]) mism++;
        chk(mism == 0, "R9 overlap result equals original source", mism, 0);
        if (ev_q.size() > 1)
            chk(ev_q[1] == ((1 << 24) | (dst + 51 * 2)), "R9 first write at far corner", ev_q[1],
                (1 << 24) | (dst + 51 * 2));
    endtask

    // R9 mirror via destination column reverse only
    task automatic t_copy_mirror();
        set_src(24'hC00); set_dst(24'hD00); set_w(4); set_h(2);
        send(cw(8'h21, 24'h000020));
        wait_idle("R11 mirror copy ends");
        model_copy(0, 1, 0, 0);
        compare_mem("R9 bit 5 mirrors destination columns");
        chk(mem_arr[widx(24'hD00)] === mem_arr[widx(24'hC06)], "R9 mirror corner",
            int'(mem_arr[widx(24'hD00)]), int'(mem_arr[widx(24'hC06)]));
    endtask

    // R1 loads stalled while busy, R4 colour
    task automatic t_busy_stall();
        logic [15:0] old_c;
        set_dst(24'hE00); set_w(8); set_h(4); set_color(16'hAAAA);
        old_c = cur_color;
        send(cw(8'h23, 24'h0));
        @(negedge clk);
        chk(!cmd_ready, "R1 cmd_ready low while busy", int'(cmd_ready), 0);
        model_fill();
        send(cw(8'h0B, 24'h005555));
        chk(!busy, "R1 load taken only when idle", int'(busy), 0);
        compare_mem("R1 running fill kept old colour");
        cur_color = 16'h5555;
        set_dst(24'hF00); set_w(2); set_h(1);
        send(cw(8'h23, 24'h0));
        wait_idle("R11 second fill ends");
        model_fill();
        compare_mem("R4 new colour after stalled load");
        chk(old_c != cur_color, "R4 colours differ", int'(old_c), int'(cur_color));
    endtask

    // R13 unknown opcodes ignored
    task automatic t_unknown();
        ev_q.delete();
        send(cw(8'h55, 24'hFFFFFF));
        send(cw(8'h24, 24'h00FFFF));
        send(cw(8'h08, 24'h000123));
        repeat (3) @(negedge clk);
        chk(ev_q.size() == 0, "R13 no memory access", ev_q.size(), 0);
        chk(!busy, "R13 no operation started", int'(busy), 0);
        set_dst(24'h1100);
        send(cw(8'h23, 24'h0));
        wait_idle("R11 fill after unknown ends");
        model_fill();
        compare_mem("R13 parameters unchanged");
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_data = '0;
        mem_ready = 1'b1;
        cur_pitch = 320;
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem_arr[i] = 16'((i * 37) ^ 16'h5A5A);
            exp_arr[i] = 16'((i * 37) ^ 16'h5A5A);
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_default_pitch();
        t_fill_small();
        t_copy_fwd();
        t_copy_overlap();
        t_copy_mirror();
        t_busy_stall();
        t_unknown();
        chk(hold_err == 0, "R10 stable request", hold_err, 0);
        chk(done_err == 0, "R11 done after last write", done_err, 0);
        chk(irq_err == 0, "R12 irq only with done", irq_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule